// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register File

This block holds the control and status registers for a host controller that serves two storage channels. Software reaches it over a simple byte-addressed bus with a 9-bit address and 32-bit data. Each request lasts one cycle, and read data comes back one cycle after the request. For each channel the block keeps the following:

- a bus-master command byte
- a bus-master status byte
- a 32-bit descriptor table address
- a 6-bit scratch byte
- a serial control field
- an interrupt-enable field
- a configuration word, whose bit 11 mirrors the channel's interrupt request

Two summary words let one read collect the command, status and interrupt state. A summary word at 0x10 covers both channels, and one at 0x18 covers channel 1. Writes to 0x10-0x12 and 0x18-0x1a act as aliases of the per-channel command, scratch and status bytes.

The external DMA engine sees command writes through a one-cycle strobe. The engine also feeds the status byte: an active level and two event pulses, for error and interrupt. A write of 1 to bit 0 of a serial control register sends a one-cycle reset pulse to that channel's bus. A single interrupt output is the OR of both channels' pending flags.

Top module: `scr_regfile`

## Requirements
- R1: After reset every stored register reads zero, the configuration words (0xa0, 0xe0) read 0x65150000, and irq, cmd_stb, bus_rst and rd_valid are low.
- R2: A write to the command byte (channel 0 at 0x00 or 0x10, channel 1 at 0x08 or 0x18) stores wdata[7:0]. In the next cycle cmd_stb[ch] is high for one cycle, and cmd_data carries the new byte.
- R3: The scratch byte (0x01/0x11 for channel 0, 0x09/0x19 for channel 1) keeps only wdata[5:0] and reads back zero-extended.
- R4: Writes to the status byte (0x02/0x12 for channel 0, 0x0a/0x1a for channel 1) affect its bits as follows:
  - Bits 6:5 load from wdata.
  - A written 1 in bit 1 or bit 2 clears that bit, and a written 0 holds it.
  - Bits 7, 4 and 3 read zero.
  - An eng_err or eng_int pulse sets bit 1 or bit 2, and the pulse wins over a clear in the same cycle.
- R5: Status bit 0 equals eng_act[ch] sampled on the previous clock edge, and writes never change it.
- R6: The table address has a base of 0x04 for channel 0 and 0x0c for channel 1. A write at base+0 loads all 32 bits. A write at base+k (k=1..3) loads only byte k from wdata[7:0]. A read at base+k returns the address shifted right by 8k bits.
- R7: A read at 0x10 returns the following fields:
  - Bits 31:24 hold the channel 1 status.
  - Bits 23:16 hold the channel 0 status.
  - Bit 14 holds channel 1 status bit 2.
  - Bits 7:0 hold the channel 0 command, with bit 4 ORed with pending[0] and bit 6 ORed with pending[1].
- R8: A read at 0x18 returns the channel 1 status in bits 23:16 and the channel 1 command in bits 7:0, with bit 4 ORed with pending[1].
- R9: The pending flag is bit 11 of the configuration word and follows chan_irq[ch] one cycle later. irq is the OR of both pending flags.
- R10: The serial control register (0x100, 0x180) keeps wdata[11:0]. A write with wdata[0]=1 pulses bus_rst[ch] for one cycle, in the next cycle.
- R11: The serial status word (0x104, 0x184) reads 0x113 while drv_present[ch] is high, and 0 otherwise.
- R12: The interrupt-enable register (0x148, 0x1c8) stores wdata[31:16] & 0x3eed and reads it back in bits 31:16, with bits 15:0 zero.
- R13: Unmapped addresses, bytes 0x03 and 0x0b, and reads at the write-only aliases return zero. A write to an unmapped address changes no register.
- R14: A read raises rd_valid with rd_data in the cycle after the request. rd_valid stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 32 | Write data |
| chan_irq | input | 2 | Per-channel interrupt request level |
| drv_present | input | 2 | Per-channel drive-present level |
| eng_act | input | 2 | DMA engine active level per channel |
| eng_err | input | 2 | DMA engine error event pulse per channel |
| eng_int | input | 2 | DMA engine interrupt event pulse per channel |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data valid |
| irq | output | 1 | Combined interrupt |
| cmd_stb | output | 2 | Command-write strobe per channel |
| cmd_data | output | 8 | Command byte for the strobed channel |
| bus_rst | output | 2 | Bus-reset pulse per channel |

## Verification
The bench targets several corner cases, each with the fault it would expose:

- Status writes at the aliased addresses. A design that decodes only the primary address would leave the status unchanged.
- A write-one-to-clear arriving in the same cycle as an engine event. A design that lets the clear win would lose an interrupt.
- Writes attempting to change the status bit 0 active flag. A design that leaves it writable would report a transfer that never ran.
- Byte writes into the table address. A design that shifts the byte wrongly would corrupt the other three bytes.
- Summary-word reads while the interrupt levels toggle. Bit 4, bit 6 or bit 14 taken from the wrong channel would produce a wrong summary word.
- Interrupt-enable writes with all upper bits set. A missing mask would leave bits that must read zero set.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;
  localparam int CMD_W  = 8;
  localparam int SWD_W  = 6;
  localparam int SCTL_W = 12;
  localparam int SIEN_W = 16;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [7:0]        sts;
    logic [DATA_W-1:0] tbl;
    logic [SWD_W-1:0]  swd;
    logic              pend;
    logic [SCTL_W-1:0] sctl;
    logic [SIEN_W-1:0] sien;
  } chan_view_t;
endpackage

// File: rtl/scr_chan.sv
module scr_chan
  import scr_pkg::*;
#(
  parameter int              CH        = 0,
  parameter logic [SIEN_W-1:0] SIEN_MASK = 16'h3eed
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_in,
  input  logic              act_in,
  input  logic              err_set,
  input  logic              int_set,
  output chan_view_t        view,
  output logic              stb,
  output logic              brst
);
  localparam int A_BLK  = CH * 8;
  localparam int A_ALT  = 16 + CH * 8;
  localparam int A_TBL  = A_BLK + 4;
  localparam int A_SCTL = 256 + CH * 128;
  localparam int A_SIEN = 256 + 72 + CH * 128;

  logic wr_cmd, wr_swd, wr_sts, wr_tbl, wr_sctl, wr_sien;
  chan_view_t q, n;
  logic stb_q, stb_n, brst_q, brst_n;

  always_comb begin
    wr_cmd  = wr_en && (addr == ADDR_W'(A_BLK)     || addr == ADDR_W'(A_ALT));
    wr_swd  = wr_en && (addr == ADDR_W'(A_BLK + 1) || addr == ADDR_W'(A_ALT + 1));
    wr_sts  = wr_en && (addr == ADDR_W'(A_BLK + 2) || addr == ADDR_W'(A_ALT + 2));
    wr_tbl  = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(A_TBL / 4));
    wr_sctl = wr_en && (addr == ADDR_W'(A_SCTL));
    wr_sien = wr_en && (addr == ADDR_W'(A_SIEN));
  end

  always_comb begin
    n = q;
    if (wr_cmd) n.cmd = wdata[CMD_W-1:0];
    if (wr_swd) n.swd = wdata[SWD_W-1:0];
    n.sts[0] = act_in;
    n.sts[1] = err_set | (q.sts[1] & ~(wr_sts & wdata[1]));
    n.sts[2] = int_set | (q.sts[2] & ~(wr_sts & wdata[2]));
    if (wr_sts) n.sts[6:5] = wdata[6:5];
    n.sts[4:3] = 2'b00;
    n.sts[7]   = 1'b0;
    if (wr_tbl) begin
      if (addr[1:0] == 2'd0) n.tbl = wdata;
      else n.tbl[addr[1:0]*8 +: 8] = wdata[7:0];
    end
    n.pend = irq_in;
    if (wr_sctl) n.sctl = wdata[SCTL_W-1:0];
    if (wr_sien) n.sien = wdata[DATA_W-1:DATA_W-SIEN_W] & SIEN_MASK;
    stb_n  = wr_cmd;
    brst_n = wr_sctl & wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      stb_q  <= 1'b0;
      brst_q <= 1'b0;
    end else begin
      q      <= n;
      stb_q  <= stb_n;
      brst_q <= brst_n;
    end
  end

  assign view = q;
  assign stb  = stb_q;
  assign brst = brst_q;
endmodule

// File: rtl/scr_rdmux.sv
module scr_rdmux
  import scr_pkg::*;
#(
  parameter logic [15:0]       CONF_ID  = 16'h6515,
  parameter logic [DATA_W-1:0] SSTS_VAL = 32'h113
) (
  input  logic [ADDR_W-1:0]         addr,
  input  chan_view_t [NCH-1:0]      views,
  input  logic [NCH-1:0]            present,
  output logic [DATA_W-1:0]         data
);
  always_comb begin
    data = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr == ADDR_W'(ch * 8))     data = DATA_W'(views[ch].cmd);
      if (addr == ADDR_W'(ch * 8 + 1)) data = DATA_W'(views[ch].swd);
      if (addr == ADDR_W'(ch * 8 + 2)) data = DATA_W'(views[ch].sts);
      if (addr[ADDR_W-1:2] == (ADDR_W-2)'((ch * 8 + 4) / 4))
        data = views[ch].tbl >> (addr[1:0] * 8);
      if (addr == ADDR_W'(160 + ch * 64))
        data = {CONF_ID, 4'b0, views[ch].pend, 11'b0};
      if (addr == ADDR_W'(256 + ch * 128))
        data = DATA_W'(views[ch].sctl);
      if (addr == ADDR_W'(260 + ch * 128))
        data = present[ch] ? SSTS_VAL : '0;
      if (addr == ADDR_W'(328 + ch * 128))
        data = {views[ch].sien, 16'b0};
    end
    if (addr == ADDR_W'(16))
      data = {views[1].sts, views[0].sts, 1'b0, views[1].sts[2], 6'b0,
              views[0].cmd | {1'b0, views[1].pend, 1'b0, views[0].pend, 4'b0}};
    if (addr == ADDR_W'(24))
      data = {8'b0, views[1].sts, 8'b0,
              views[1].cmd | {3'b0, views[1].pend, 4'b0}};
  end
endmodule

// File: rtl/scr_regfile.sv
module scr_regfile
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NCH-1:0]    chan_irq,
  input  logic [NCH-1:0]    drv_present,
  input  logic [NCH-1:0]    eng_act,
  input  logic [NCH-1:0]    eng_err,
  input  logic [NCH-1:0]    eng_int,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq,
  output logic [NCH-1:0]    cmd_stb,
  output logic [CMD_W-1:0]  cmd_data,
  output logic [NCH-1:0]    bus_rst
);
  chan_view_t [NCH-1:0] views;
  logic [NCH-1:0]       pend_vec;
  logic                 wr_en, rd_en;
  logic [DATA_W-1:0]    mux_data, rd_data_q, rd_data_n;
  logic                 rd_valid_q;

  assign wr_en = req_valid &  req_write;
  assign rd_en = req_valid & ~req_write;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    scr_chan #(.CH(g)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .irq_in  (chan_irq[g]),
      .act_in  (eng_act[g]),
      .err_set (eng_err[g]),
      .int_set (eng_int[g]),
      .view    (views[g]),
      .stb     (cmd_stb[g]),
      .brst    (bus_rst[g])
    );
    assign pend_vec[g] = views[g].pend;
  end

  scr_rdmux u_rdmux (
    .addr    (req_addr),
    .views   (views),
    .present (drv_present),
    .data    (mux_data)
  );

  always_comb rd_data_n = rd_en ? mux_data : rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_n;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign irq      = |pend_vec;
  assign cmd_data = cmd_stb[1] ? views[1].cmd : views[0].cmd;
endmodule

// File: rtl/scr_regfile_chk.sv
module scr_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [8:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic [1:0]  chan_irq,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        irq,
  input logic [1:0]  cmd_stb,
  input logic [7:0]  cmd_data,
  input logic [1:0]  bus_rst
);
  // R2
  cmd0_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_addr == 9'h000 || req_addr == 9'h010)) |=> cmd_stb[0]);
  // R2
  cmd1_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 9'h008) |=> (cmd_stb[1] && cmd_data == $past(req_wdata[7:0])));
  // R14
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  // R14
  no_rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|chan_irq)));
  // R10
  bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 9'h180 && req_wdata[0]) |=> bus_rst[1]);
endmodule

bind scr_regfile scr_regfile_chk u_chk (.*);

// File: tb/scr_regfile_test.sv
`timescale 1ns/1ps
module scr_regfile_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_write, irq_o, rd_valid;
  logic [8:0] req_addr;
  logic [31:0] req_wdata, rd_data;
  logic [1:0] chan_irq, drv_present, eng_act, eng_err, eng_int, cmd_stb, bus_rst;
  logic [7:0] cmd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  scr_regfile uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .chan_irq(chan_irq), .drv_present(drv_present),
    .eng_act(eng_act), .eng_err(eng_err), .eng_int(eng_int), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq(irq_o), .cmd_stb(cmd_stb), .cmd_data(cmd_data), .bus_rst(bus_rst));

  logic [7:0]  m_cmd[2], m_sts[2];
  logic [31:0] m_tbl[2];
  logic [5:0]  m_swd[2];
  logic [11:0] m_sctl[2];
  logic [15:0] m_sien[2];
  logic        m_pend[2];

  function automatic logic [31:0] exp_rd(logic [8:0] a, logic [1:0] pres);
    for (int c = 0; c < 2; c++) begin
      if (a == 9'(c*8))   return 32'(m_cmd[c]);
      if (a == 9'(c*8+1)) return 32'(m_swd[c]);
      if (a == 9'(c*8+2)) return 32'(m_sts[c]);
      if (a >= 9'(c*8+4) && a <= 9'(c*8+7)) return m_tbl[c] >> (8*(a - 9'(c*8+4)));
      if (a == 9'(160+c*64)) return {16'h6515, 4'b0, m_pend[c], 11'b0};
      if (a == 9'(256+c*128)) return 32'(m_sctl[c]);
      if (a == 9'(260+c*128)) return pres[c] ? 32'h113 : 32'h0;
      if (a == 9'(328+c*128)) return {m_sien[c], 16'h0};
    end
    if (a == 9'h010) return {m_sts[1], m_sts[0], 1'b0, m_sts[1][2], 6'b0,
                             m_cmd[0] | {1'b0, m_pend[1], 1'b0, m_pend[0], 4'b0}};
    if (a == 9'h018) return {8'h0, m_sts[1], 8'h0, m_cmd[1] | {3'b0, m_pend[1], 4'b0}};
    return 32'h0;
  endfunction

  function automatic string req_of(logic [8:0] a);
    case (a)
      9'h000, 9'h008: return "R2";
      9'h001, 9'h009: return "R3";
      9'h002, 9'h00a: return "R4";
      9'h010: return "R7";
      9'h018: return "R8";
      9'h0a0, 9'h0e0: return "R9";
      9'h100, 9'h180: return "R10";
      9'h104, 9'h184: return "R11";
      9'h148, 9'h1c8: return "R12";
      default: return (a[8:2] == 7'd1 || a[8:2] == 7'd3) ? "R6" : "R13";
    endcase
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic op(bit wr, logic [8:0] a, logic [31:0] d, logic [1:0] irq_i,
                    logic [1:0] act, logic [1:0] err, logic [1:0] itr, logic [1:0] pres);
    logic [31:0] e;
    logic [1:0] e_stb, e_rst;
    logic [7:0] e_cd;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    chan_irq = irq_i; eng_act = act; eng_err = err; eng_int = itr; drv_present = pres;
    e = exp_rd(a, pres);
    e_stb = 0; e_rst = 0; e_cd = 0;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      bit ws;
      ws = wr && (a == 9'(c*8+2) || a == 9'(c*8+18));
      if (wr && (a == 9'(c*8) || a == 9'(c*8+16))) begin m_cmd[c] = d[7:0]; e_stb[c] = 1; e_cd = d[7:0]; end
      if (wr && (a == 9'(c*8+1) || a == 9'(c*8+17))) m_swd[c] = d[5:0];
      m_sts[c][1] = err[c] | (m_sts[c][1] & ~(ws & d[1]));
      m_sts[c][2] = itr[c] | (m_sts[c][2] & ~(ws & d[2]));
      if (ws) m_sts[c][6:5] = d[6:5];
      m_sts[c][0] = act[c];
      if (wr && a == 9'(c*8+4)) m_tbl[c] = d;
      for (int k = 1; k < 4; k++) if (wr && a == 9'(c*8+4+k)) m_tbl[c][8*k +: 8] = d[7:0];
      if (wr && a == 9'(256+c*128)) begin m_sctl[c] = d[11:0]; e_rst[c] = d[0]; end
      if (wr && a == 9'(328+c*128)) m_sien[c] = d[31:16] & 16'h3eed;
      m_pend[c] = irq_i[c];
    end
    @(negedge clk);
    check("R14 rd_valid", 32'(rd_valid), 32'(!wr));
    if (!wr) check(req_of(a), rd_data, e);
    check("R2 cmd_stb", 32'(cmd_stb), 32'(e_stb));
    if (e_stb != 0) check("R2 cmd_data", 32'(cmd_data), 32'(e_cd));
    check("R10 bus_rst", 32'(bus_rst), 32'(e_rst));
    check("R9 irq", 32'(irq_o), 32'(m_pend[0] | m_pend[1]));
  endtask

  localparam logic [8:0] ADDRS [28] = '{9'h000, 9'h001, 9'h002, 9'h003, 9'h004, 9'h005, 9'h006,
    9'h007, 9'h008, 9'h009, 9'h00a, 9'h00b, 9'h00c, 9'h00f, 9'h010, 9'h011, 9'h012, 9'h018,
    9'h01a, 9'h0a0, 9'h0e0, 9'h100, 9'h104, 9'h148, 9'h180, 9'h184, 9'h1c8, 9'h1ff};

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] ri, ra, rp;
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_sts[c] = 0; m_tbl[c] = 0; m_swd[c] = 0;
      m_sctl[c] = 0; m_sien[c] = 0; m_pend[c] = 0;
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    chan_irq = 0; drv_present = 0; eng_act = 0; eng_err = 0; eng_int = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at ports
    check("R1 irq", 32'(irq_o), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 cmd_stb", 32'(cmd_stb), 0);
    check("R1 bus_rst", 32'(bus_rst), 0);
    op(0, 9'h0a0, 0, 0, 0, 0, 0, 0);   // R1 config word
    op(0, 9'h0e0, 0, 0, 0, 0, 0, 0);   // R1
    op(0, 9'h004, 0, 0, 0, 0, 0, 0);   // R1 table
    // R4 interrupt event, then alias clear racing a new event: set wins
    op(0, 9'h000, 0, 0, 0, 0, 2'b01, 0);
    op(1, 9'h012, 32'h0000_0064, 0, 0, 0, 2'b01, 0);
    op(0, 9'h002, 0, 0, 0, 0, 0, 0);
    op(1, 9'h012, 32'h0000_00ff, 0, 0, 0, 0, 0);
    op(0, 9'h002, 0, 0, 0, 0, 0, 0);
    // R5 active flag cannot be written
    op(1, 9'h00a, 32'h0000_0001, 0, 2'b10, 0, 0, 0);
    op(1, 9'h01a, 32'h0000_0000, 0, 2'b10, 2'b10, 2'b10, 0);
    op(0, 9'h00a, 0, 0, 0, 0, 0, 0);
    // R7 R8 summary with interrupts pending
    op(1, 9'h008, 32'h0000_00a5, 2'b11, 0, 0, 0, 0);
    op(0, 9'h010, 0, 2'b10, 0, 0, 0, 0);
    op(0, 9'h018, 0, 2'b00, 0, 0, 0, 0);
    // R6 byte writes into table
    op(1, 9'h00c, 32'h1122_3344, 0, 0, 0, 0, 0);
    op(1, 9'h00e, 32'h0000_00ee, 0, 0, 0, 0, 0);
    op(0, 9'h00c, 0, 0, 0, 0, 0, 0);
    op(0, 9'h00f, 0, 0, 0, 0, 0, 0);
    // R12 mask, R11 presence, R13 unmapped write ignored
    op(1, 9'h148, 32'hffff_ffff, 0, 0, 0, 0, 0);
    op(0, 9'h148, 0, 0, 0, 0, 0, 2'b01);
    op(0, 9'h184, 0, 0, 0, 0, 0, 2'b10);
    op(1, 9'h011, 32'hffff_ffff, 0, 0, 0, 0, 0);   // R3
    op(0, 9'h001, 0, 0, 0, 0, 0, 0);
    op(1, 9'h1ff, 32'hffff_ffff, 0, 0, 0, 0, 0);
    op(0, 9'h1ff, 0, 0, 0, 0, 0, 0);
    op(1, 9'h100, 32'hffff_f001, 0, 0, 0, 0, 0);    // R10
    op(0, 9'h100, 0, 0, 0, 0, 0, 0);
    ri = 0; ra = 0; rp = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] a;
      if ($urandom % 8 == 0) ri = 2'($urandom);
      if ($urandom % 8 == 0) ra = 2'($urandom);
      if ($urandom % 8 == 0) rp = 2'($urandom);
      a = ADDRS[$urandom % 28];
      op($urandom % 2 == 0, a, $urandom, ri, ra,
         ($urandom % 10 == 0) ? 2'($urandom) : 2'b00,
         ($urandom % 10 == 0) ? 2'($urandom) : 2'b00, rp);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule